// File: doc/BRIEF.md
# Full-bridge gate command generator

This block converts one comparison bit and two control inputs into four gate commands for an N-channel full bridge. The bridge has two legs, A and B. Each leg has a low and a high switch. The compare bit chooses the diagonal that conducts. A high-side enable input can withhold both upper switches, so that the load current freewheels through the two bottom switches. A disable input overrides everything and turns all four switches off.

Every turn-off takes effect on the next clock edge. Every turn-on waits a programmable number of clock cycles, which places dead time between the two switches of a leg. The upper pair has one delay and the lower pair has another. When the disable input is released, both lower switches are pulsed on together for a fixed refresh interval, so the bootstrap capacitors can recharge. The upper switches then stay off until a longer release window has passed. All timing is expressed in clock cycles, through parameters.

Top module: `fbridge_gate_ctl`

## Requirements
- R1: A synchronous active-high `rst` sampled at an edge drives all four gate outputs and `overlap_err_o` low after that edge, and the block leaves reset in the disabled phase.
- R2: `dis_i` sampled high at an edge drives all four gate outputs low after that edge, whatever `cmp_i` and `hi_en_i` are.
- R3: After the release window, with `dis_i` low and `hi_en_i` high, `cmp_i`=1 settles to `b_lo_o`=1 and `a_hi_o`=1 with the other two at 0. `cmp_i`=0 settles to `a_lo_o`=1 and `b_hi_o`=1 with the other two at 0.
- R4: `hi_en_i` sampled low drives `a_hi_o` and `b_hi_o` low after that edge. The lower pair keeps following `cmp_i`: `b_lo_o` is on for `cmp_i`=1 and `a_lo_o` is on for `cmp_i`=0.
- R5: A gate output whose on-condition is false at an edge goes low after that same edge, with no added delay. The one exception is a lower output during refresh.
- R6: A gate output whose on-condition is first sampled true at edge k, and stays true, rises after edge k+LDEL_CYC for a lower switch or edge k+HDEL_CYC for an upper switch. A delay of 0 means it rises on the next edge. A shorter true interval produces no pulse.
- R7: The release edge E0 is the first edge that samples `dis_i` low while the block is disabled. No gate output rises at E0. Both lower outputs are high after edges E1 through E(REFRESH_CYC), regardless of `cmp_i`.
- R8: Both upper outputs stay low through edge E(UEN_CYC+HDEL_CYC). An upper output whose condition holds from E(UEN_CYC+1) onward rises at edge E(UEN_CYC+1+HDEL_CYC). UEN_CYC must exceed REFRESH_CYC.
- R9: The two switches of one leg are never high in the same cycle. `overlap_err_o` is a sticky flag, cleared only by reset, that rises if they ever are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_i | input | 1 | Comparison bit; 1 selects the B-low / A-high diagonal |
| hi_en_i | input | 1 | High-side enable; low forces freewheeling on the lower pair |
| dis_i | input | 1 | Global disable; high turns all switches off |
| a_lo_o | output | 1 | Leg A lower switch command |
| a_hi_o | output | 1 | Leg A upper switch command |
| b_lo_o | output | 1 | Leg B lower switch command |
| b_hi_o | output | 1 | Leg B upper switch command |
| overlap_err_o | output | 1 | Sticky flag: both switches of a leg were commanded on together |

## Verification
Some functions can act in the same cycle. The end of the refresh pulse can coincide with a compare level that keeps one lower switch on and drops the other. A disable can arrive in the very cycle a delayed turn-on would complete, or during refresh itself. These cases are provoked in two ways: by directed sequences that release and re-assert `dis_i` mid-refresh and flip `cmp_i` just as the refresh ends, and by a long random run that toggles all three inputs. A behavioural model built from cycle counts is compared with the four outputs and the error flag on every clock. It judges which function wins: disable beats refresh, and refresh beats a compare-driven turn-off.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int LEGS   = 2;
  localparam int NSW    = 2 * LEGS;   // switch index: 2*leg = lower, 2*leg+1 = upper

  typedef enum logic [1:0] {
    RS_OFF  = 2'd0,   // disabled: nothing may conduct
    RS_WAIT = 2'd1,   // released: refresh pulse, then uppers still held off
    RS_RUN  = 2'd2    // normal operation
  } rel_state_e;
endpackage

// File: rtl/fbg_release_seq.sv
module fbg_release_seq #(
  parameter int REFRESH_CYC = 33,
  parameter int UEN_CYC     = 42
) (
  input  logic clk,
  input  logic rst,
  input  logic dis_i,
  output logic active_o,
  output logic refresh_o,
  output logic run_o
);
  import fbg_pkg::*;

  localparam int UW = $clog2(UEN_CYC + 1);
  localparam logic [UW-1:0] LAST_V = UW'(UEN_CYC - 1);
  localparam logic [UW-1:0] REF_V  = UW'(REFRESH_CYC);

  rel_state_e    st;
  logic [UW-1:0] age;

  always_ff @(posedge clk) begin
    if (rst || dis_i) begin
      st  <= RS_OFF;
      age <= '0;
    end else begin
      case (st)
        RS_OFF:  begin
          st  <= RS_WAIT;
          age <= '0;
        end
        RS_WAIT: begin
          if (age == LAST_V) st <= RS_RUN;
          else               age <= age + 1'b1;
        end
        RS_RUN:  st <= RS_RUN;
        default: st <= RS_OFF;
      endcase
    end
  end

  assign active_o  = (st != RS_OFF);
  assign refresh_o = (st == RS_WAIT) && (age < REF_V);
  assign run_o     = (st == RS_RUN);
endmodule

// File: rtl/fbg_on_delay.sv
module fbg_on_delay #(
  parameter int DEL = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic force_i,
  output logic q_o
);
  localparam int CW = (DEL < 1) ? 1 : $clog2(DEL + 1);
  localparam logic [CW-1:0] DEL_V = CW'(DEL);

  logic [CW-1:0] held;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_o  <= 1'b0;
      held <= '0;
    end else if (force_i) begin
      q_o  <= 1'b1;
      held <= DEL_V;
    end else if (!req_i) begin
      q_o  <= 1'b0;           // turn-off never waits
      held <= '0;
    end else if (held >= DEL_V) begin
      q_o  <= 1'b1;
      held <= DEL_V;
    end else begin
      held <= held + 1'b1;
    end
  end
endmodule

// File: rtl/fbg_leg_guard.sv
module fbg_leg_guard
  import fbg_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [NSW-1:0] gate_i,
  output logic           err_o
);
  logic [LEGS-1:0] clash;

  for (genvar l = 0; l < LEGS; l++) begin : g_leg
    assign clash[l] = gate_i[2*l] & gate_i[2*l+1];
  end

  always_ff @(posedge clk) begin
    if (rst)         err_o <= 1'b0;
    else if (|clash) err_o <= 1'b1;
  end
endmodule

// File: rtl/fbridge_gate_ctl.sv
module fbridge_gate_ctl #(
  parameter int REFRESH_CYC = 33,
  parameter int UEN_CYC     = 42,
  parameter int HDEL_CYC    = 3,
  parameter int LDEL_CYC    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cmp_i,
  input  logic hi_en_i,
  input  logic dis_i,
  output logic a_lo_o,
  output logic a_hi_o,
  output logic b_lo_o,
  output logic b_hi_o,
  output logic overlap_err_o
);
  import fbg_pkg::*;

  logic           active_w, refresh_w, run_w, live_w;
  logic [NSW-1:0] req_w, frc_w, gate_w;

  fbg_release_seq #(
    .REFRESH_CYC(REFRESH_CYC),
    .UEN_CYC    (UEN_CYC)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .dis_i    (dis_i),
    .active_o (active_w),
    .refresh_o(refresh_w),
    .run_o    (run_w)
  );

  assign live_w = ~dis_i;

  // leg A upper conducts on cmp=1, leg B upper on cmp=0; lowers are the complement
  for (genvar l = 0; l < LEGS; l++) begin : g_req
    logic up_sel;
    assign up_sel       = (l == 0) ? cmp_i : ~cmp_i;
    assign req_w[2*l]   = live_w & active_w & ~up_sel;
    assign req_w[2*l+1] = live_w & run_w & hi_en_i & up_sel;
    assign frc_w[2*l]   = live_w & refresh_w;
    assign frc_w[2*l+1] = 1'b0;
  end

  for (genvar i = 0; i < NSW; i++) begin : g_sw
    fbg_on_delay #(
      .DEL((i % 2 == 1) ? HDEL_CYC : LDEL_CYC)
    ) u_dly (
      .clk    (clk),
      .rst    (rst),
      .req_i  (req_w[i]),
      .force_i(frc_w[i]),
      .q_o    (gate_w[i])
    );
  end

  fbg_leg_guard u_guard (
    .clk   (clk),
    .rst   (rst),
    .gate_i(gate_w),
    .err_o (overlap_err_o)
  );

  assign a_lo_o = gate_w[0];
  assign a_hi_o = gate_w[1];
  assign b_lo_o = gate_w[2];
  assign b_hi_o = gate_w[3];
endmodule

// File: rtl/fbridge_gate_ctl_chk.sv
module fbridge_gate_ctl_chk (
  input logic clk,
  input logic rst,
  input logic cmp_i,
  input logic hi_en_i,
  input logic dis_i,
  input logic a_lo_o,
  input logic a_hi_o,
  input logic b_lo_o,
  input logic b_hi_o,
  input logic overlap_err_o,
  input logic refresh,
  input logic run
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> !(a_lo_o || a_hi_o || b_lo_o || b_hi_o || overlap_err_o));

  assert_disable_wins_R2: assert property (@(posedge clk) disable iff (rst)
    dis_i |=> !(a_lo_o || a_hi_o || b_lo_o || b_hi_o));

  assert_freewheel_R4: assert property (@(posedge clk) disable iff (rst)
    !hi_en_i |=> (!a_hi_o && !b_hi_o));

  assert_upper_a_off_R5: assert property (@(posedge clk) disable iff (rst)
    !cmp_i |=> !a_hi_o);

  assert_upper_b_off_R5: assert property (@(posedge clk) disable iff (rst)
    cmp_i |=> !b_hi_o);

  assert_lower_a_off_R5: assert property (@(posedge clk) disable iff (rst)
    (cmp_i && !refresh) |=> !a_lo_o);

  assert_refresh_pair_R7: assert property (@(posedge clk) disable iff (rst)
    (refresh && !dis_i) |=> (a_lo_o && b_lo_o));

  assert_upper_window_R8: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!a_hi_o && !b_hi_o));

  assert_leg_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(a_lo_o && a_hi_o) && !(b_lo_o && b_hi_o));

  assert_no_overlap_flag_R9: assert property (@(posedge clk) disable iff (rst)
    !overlap_err_o);
endmodule

bind fbridge_gate_ctl fbridge_gate_ctl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmp_i        (cmp_i),
  .hi_en_i      (hi_en_i),
  .dis_i        (dis_i),
  .a_lo_o       (a_lo_o),
  .a_hi_o       (a_hi_o),
  .b_lo_o       (b_lo_o),
  .b_hi_o       (b_hi_o),
  .overlap_err_o(overlap_err_o),
  .refresh      (refresh_w),
  .run          (run_w)
);

// File: tb/fbridge_gate_ctl_bench.sv
`timescale 1ns/1ps
module fbridge_gate_ctl_bench;
  localparam int REF  = 33;
  localparam int UEN  = 42;
  localparam int HDEL = 3;
  localparam int LDEL = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp = 1'b1;
  logic hen = 1'b1;
  logic dis = 1'b0;
  logic a_lo, a_hi, b_lo, b_hi, err;

  always #4 clk = ~clk;   // 125 MHz

  fbridge_gate_ctl #(
    .REFRESH_CYC(REF), .UEN_CYC(UEN), .HDEL_CYC(HDEL), .LDEL_CYC(LDEL)
  ) u_fbridge_gate_ctl (
    .clk(clk), .rst(rst), .cmp_i(cmp), .hi_en_i(hen), .dis_i(dis),
    .a_lo_o(a_lo), .a_hi_o(a_hi), .b_lo_o(b_lo), .b_hi_o(b_hi),
    .overlap_err_o(err)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- behavioural reference model ----------------
  // age: edges since release (-1 = disabled); streak: consecutive request edges
  int         age = -1;
  int         streak [4];
  logic [3:0] m_exp = 4'b0;
  string      m_tag = "R1";
  bit         m_live = 0;
  bit         m_off, m_refr, m_run;
  logic [3:0] m_want;

  always @(posedge clk) begin
    m_live = 1;
    if (rst || dis) begin
      age = -1;
      for (int i = 0; i < 4; i++) streak[i] = 0;
      m_exp = 4'b0;
      m_tag = rst ? "R1" : "R2";
    end else begin
      m_off  = (age < 0);
      m_refr = !m_off && (age < REF);
      m_run  = !m_off && (age >= UEN);
      m_want[0] = !m_off && !cmp;
      m_want[1] = m_run && hen && cmp;
      m_want[2] = !m_off && cmp;
      m_want[3] = m_run && hen && !cmp;
      for (int i = 0; i < 4; i++) begin
        if (m_refr && (i % 2 == 0)) begin
          streak[i] = 1000;
          m_exp[i]  = 1'b1;
        end else if (m_want[i]) begin
          if (streak[i] < 1000) streak[i] = streak[i] + 1;
          m_exp[i] = (streak[i] > ((i % 2 == 1) ? HDEL : LDEL));
        end else begin
          streak[i] = 0;
          m_exp[i]  = 1'b0;
        end
      end
      if (m_refr)       m_tag = "R7";
      else if (!m_run)  m_tag = "R8";
      else if (!hen)    m_tag = "R4";
      else              m_tag = "R3";
      if (m_off)            age = 0;
      else if (age < 1000)  age = age + 1;
    end
  end

  always @(negedge clk) begin
    if (m_live && !finished) begin
      chk({m_tag, " model"}, {b_hi, b_lo, a_hi, a_lo}, m_exp);
      chk("R9 overlap flag", err, 0);
    end
  end

  // ---------------- directed and random stimulus ----------------
  initial begin
    step(3);
    chk("R1 reset outputs", {b_hi, b_lo, a_hi, a_lo, err}, 0);
    rst = 1'b0;                       // next edge is the release edge E0
    step(1);
    chk("R7 nothing at E0", {b_hi, b_lo, a_hi, a_lo}, 0);
    step(1);
    chk("R7 refresh starts", {b_lo, a_lo}, 2'b11);
    step(REF - 1);
    chk("R7 refresh last edge", {b_lo, a_lo}, 2'b11);
    step(1);
    chk("R5 a_lo drops after refresh", {b_lo, a_lo}, 2'b10);
    step(UEN + HDEL - REF - 1);
    chk("R8 upper held through window", a_hi, 0);
    step(1);
    chk("R8 upper first rise", a_hi, 1);
    chk("R3 diagonal cmp=1", {b_hi, b_lo, a_hi, a_lo}, 4'b0110);

    cmp = 1'b0;
    step(1);
    chk("R5 immediate turn-off", {b_lo, a_hi}, 2'b00);
    step(LDEL - 1);
    chk("R6 lower still waiting", a_lo, 0);
    step(1);
    chk("R6 lower on after LDEL", a_lo, 1);
    step(HDEL - LDEL - 1);
    chk("R6 upper still waiting", b_hi, 0);
    step(1);
    chk("R6 upper on after HDEL", b_hi, 1);
    chk("R3 diagonal cmp=0", {b_hi, b_lo, a_hi, a_lo}, 4'b1001);

    hen = 1'b0;
    step(1);
    chk("R4 uppers dropped", {b_hi, a_hi}, 2'b00);
    chk("R4 lower kept", a_lo, 1);
    cmp = 1'b1;
    step(LDEL + 1);
    chk("R4 freewheel follows cmp", {b_hi, b_lo, a_hi, a_lo}, 4'b0100);
    hen = 1'b1;
    step(HDEL);
    chk("R6 upper waits after enable", a_hi, 0);
    step(1);
    chk("R6 upper on after enable", a_hi, 1);

    cmp = 1'b0;                       // pulse shorter than HDEL
    step(1);
    cmp = 1'b1;
    step(HDEL + 1);
    chk("R6 short pulse swallowed", b_hi, 0);

    dis = 1'b1;
    step(1);
    chk("R2 disable clears", {b_hi, b_lo, a_hi, a_lo}, 0);
    for (int i = 0; i < 6; i++) begin
      cmp = ~cmp;
      hen = i[0];
      step(1);
      chk("R2 disable holds", {b_hi, b_lo, a_hi, a_lo}, 0);
    end
    hen = 1'b1;
    dis = 1'b0;
    step(2);
    chk("R7 refresh after release", {b_lo, a_lo}, 2'b11);
    step(5);
    dis = 1'b1;                       // disable inside refresh
    step(1);
    chk("R2 disable beats refresh", {b_hi, b_lo, a_hi, a_lo}, 0);
    dis = 1'b0;
    step(REF + 1);
    cmp = ~cmp;                       // flip right at end of refresh
    step(UEN + 10);

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0)   cmp = ~cmp;
      if ($urandom_range(0, 31) == 0)  hen = ~hen;
      if ($urandom_range(0, 127) == 0) dis = 1'b1;
      else if (dis && $urandom_range(0, 7) == 0) dis = 1'b0;
      step(1);
    end

    rst = 1'b1;
    step(1);
    chk("R1 reset mid-run", {b_hi, b_lo, a_hi, a_lo, err}, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule